// File: doc/BRIEF.md
# Four-Channel Wiper Register Command Engine

This engine sits behind a serial front end that has already turned the bit stream into bytes. It runs the register commands of a four-channel digital potentiometer. Each channel keeps one volatile 8-bit wiper register, which drives the tap position, and a bank of four 8-bit storage registers that stand in for nonvolatile memory. The front end holds `cs_active` high for the length of a frame and pulses `byte_valid` once for each received byte.

The first byte of a frame is an instruction. It carries an opcode, a storage-register index and a channel index. Write commands take the byte that follows as their data. Read commands put the selected byte on `rd_byte` so that the front end can shift it out during the next byte slot. A storage write does not take effect at once. It stays pending for a programmable number of clock cycles, and during that time the busy flag `wip` is high. The `wp_n` input, when low, blocks storage writes. Reset stands in for power-up: every storage register takes its seed value, and one cycle later each wiper copies storage register 0 of its own channel.

Top module: `qwe_engine`

## Requirements
- R1: Instruction byte fields: bits 7:4 are the opcode, bits 3:2 are the storage-register index, bits 1:0 are the channel index. The byte after a write instruction is its data. Any further bytes in the same frame are ignored. Dropping `cs_active` makes the next byte an instruction again.
- R2: Opcode 1001 with bits 3:2 equal to 00 reads the selected channel's wiper. `rd_byte` holds the value and `rd_valid` is high for exactly one cycle, the cycle after the instruction byte is taken.
- R3: Opcode 1010 with bits 3:2 equal to 00 loads the following data byte into the selected wiper. It appears on `wiper_pos[8*c+7:8*c]` the cycle after the data byte. 00h is the low-terminal end and FFh is the high-terminal end.
- R4: Opcode 1011 reads the selected storage register of the selected channel, with the same timing as R2.
- R5: Opcode 1100 with the following data byte starts a storage write. `wip` is high for exactly `NV_DELAY` cycles starting the cycle after the data byte. The register takes the new value when `wip` falls.
- R6: Opcode 1101 copies the selected storage register into the same channel's wiper. The result is visible the cycle after the instruction byte.
- R7: After reset, storage register r of channel c holds `DR_SEED + 4*c + r`. One cycle after reset is released, each wiper equals its channel's storage register 0.
- R8: While `wp_n` is low, a storage write data byte is discarded: `wip` stays low and the register keeps its value.
- R9: While `wip` is high, a new storage write is ignored, and reads of the pending register still return its old value.
- R10: Opcodes other than the five above, and wiper reads or writes with nonzero bits 3:2, change no state and produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up model) |
| cs_active | input | 1 | High while a frame is in progress |
| byte_valid | input | 1 | One-cycle strobe for each received byte |
| byte_data | input | 8 | Received byte |
| wp_n | input | 1 | Low blocks storage writes |
| rd_byte | output | 8 | Byte returned by a read command |
| rd_valid | output | 1 | One-cycle strobe when `rd_byte` is updated |
| wip | output | 1 | Storage write in progress |
| wiper_pos | output | 32 | Four wiper positions, channel c in bits 8c+7:8c |

## Verification
The assertions check on every cycle that the busy window has its exact length and a legal cause, and that no write starts while protection is active. They also check that a read strobe lasts one cycle and follows a received byte, and that a wiper moves only after a received byte or the boot copy. Only the scenarios can show that the right register was picked, that a read of a pending register returns the old value, that a transfer copies the right storage slot, and that illegal or surplus bytes leave every register as it was.

// File: rtl/qwe_pkg.sv
package qwe_pkg;
   localparam int BYTE_W  = 8;
   localparam int CH_CNT  = 4;
   localparam int REG_CNT = 4;
   localparam int CH_W    = $clog2(CH_CNT);
   localparam int REG_W   = $clog2(REG_CNT);

   localparam logic [3:0] OPC_RD_WCR = 4'b1001;
   localparam logic [3:0] OPC_WR_WCR = 4'b1010;
   localparam logic [3:0] OPC_RD_DR  = 4'b1011;
   localparam logic [3:0] OPC_WR_DR  = 4'b1100;
   localparam logic [3:0] OPC_XFR    = 4'b1101;

   typedef enum logic [2:0] {
      OP_NONE, OP_RD_WCR, OP_WR_WCR, OP_RD_DR, OP_WR_DR, OP_XFR
   } op_e;

   typedef enum logic [1:0] {ST_INSTR, ST_DATA, ST_DONE} st_e;

   typedef struct packed {
      op_e              op;
      logic [REG_W-1:0] rsel;
      logic [CH_W-1:0]  ch;
   } cmd_t;
endpackage

// File: rtl/qwe_decode.sv
module qwe_decode
   import qwe_pkg::*;
(
   input  logic [BYTE_W-1:0] instr,
   output cmd_t              cmd
);
   logic [3:0]       opc;
   logic [REG_W-1:0] rsel;

   assign opc  = instr[7:4];
   assign rsel = instr[3:2];

   always_comb begin
      cmd.ch   = instr[1:0];
      cmd.rsel = rsel;
      unique case (opc)
         OPC_RD_WCR: cmd.op = (rsel == '0) ? OP_RD_WCR : OP_NONE;
         OPC_WR_WCR: cmd.op = (rsel == '0) ? OP_WR_WCR : OP_NONE;
         OPC_RD_DR:  cmd.op = OP_RD_DR;
         OPC_WR_DR:  cmd.op = OP_WR_DR;
         OPC_XFR:    cmd.op = OP_XFR;
         default:    cmd.op = OP_NONE;
      endcase
   end
endmodule

// File: rtl/qwe_nv_timer.sv
module qwe_nv_timer
   import qwe_pkg::*;
#(
   parameter int NV_DELAY = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wp_n,
   input  logic [CH_W-1:0]   req_ch,
   input  logic [REG_W-1:0]  req_rsel,
   input  logic [BYTE_W-1:0] req_data,
   output logic              wip,
   output logic              commit,
   output logic [CH_W-1:0]   commit_ch,
   output logic [REG_W-1:0]  commit_rsel,
   output logic [BYTE_W-1:0] commit_data
);
   localparam int CNT_W = (NV_DELAY > 1) ? $clog2(NV_DELAY) : 1;

   logic accept;
   logic done;

   assign accept = req && !wip && wp_n;
   assign commit = wip && done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip         <= 1'b0;
         commit_ch   <= '0;
         commit_rsel <= '0;
         commit_data <= '0;
      end else if (accept) begin
         wip         <= 1'b1;
         commit_ch   <= req_ch;
         commit_rsel <= req_rsel;
         commit_data <= req_data;
      end else if (commit) begin
         wip <= 1'b0;
      end
   end

   generate
      if (NV_DELAY == 1) begin : g_single
         assign done = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (accept)           cnt <= CNT_W'(NV_DELAY - 1);
            else if (wip && cnt != '0) cnt <= cnt - 1'b1;
         end
         assign done = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/qwe_channel.sv
module qwe_channel
   import qwe_pkg::*;
#(
   parameter logic [7:0] DR_SEED = 8'h40,
   parameter int         CH_IDX  = 0
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      boot,
   input  logic                      wcr_we,
   input  logic [BYTE_W-1:0]         wcr_wdata,
   input  logic                      xfr_en,
   input  logic [REG_W-1:0]          xfr_sel,
   input  logic                      dr_we,
   input  logic [REG_W-1:0]          dr_sel,
   input  logic [BYTE_W-1:0]         dr_wdata,
   output logic [BYTE_W-1:0]         wcr,
   output logic [REG_CNT*BYTE_W-1:0] dr_flat
);
   logic [BYTE_W-1:0] dr_q [REG_CNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < REG_CNT; r++)
            dr_q[r] <= BYTE_W'(int'(DR_SEED) + CH_IDX * REG_CNT + r);
      end else if (dr_we) begin
         dr_q[dr_sel] <= dr_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wcr <= '0;
      else if (boot)    wcr <= dr_q[0];
      else if (wcr_we)  wcr <= wcr_wdata;
      else if (xfr_en)  wcr <= dr_q[xfr_sel];
   end

   generate
      for (genvar r = 0; r < REG_CNT; r++) begin : g_flat
         assign dr_flat[r*BYTE_W +: BYTE_W] = dr_q[r];
      end
   endgenerate
endmodule

// File: rtl/qwe_engine.sv
module qwe_engine
   import qwe_pkg::*;
#(
   parameter int         NV_DELAY = 20,
   parameter logic [7:0] DR_SEED  = 8'h40
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_active,
   input  logic                     byte_valid,
   input  logic [BYTE_W-1:0]        byte_data,
   input  logic                     wp_n,
   output logic [BYTE_W-1:0]        rd_byte,
   output logic                     rd_valid,
   output logic                     wip,
   output logic [CH_CNT*BYTE_W-1:0] wiper_pos
);
   generate
      if (NV_DELAY < 1) begin : g_bad_delay
         $error("qwe_engine: NV_DELAY must be at least 1");
      end
      if (BYTE_W != 8 || CH_CNT != 4 || REG_CNT != 4) begin : g_bad_fmt
         $error("qwe_engine: instruction format needs 8-bit bytes, 4 channels, 4 registers");
      end
   endgenerate

   st_e  state;
   cmd_t cur;
   cmd_t dec;
   logic boot_q;

   logic take, instr_take, data_take;
   logic xfr_fire, wcr_fire, dr_req;

   logic                      commit;
   logic [CH_W-1:0]           commit_ch;
   logic [REG_W-1:0]          commit_rsel;
   logic [BYTE_W-1:0]         commit_data;
   logic [BYTE_W-1:0]         wcr_arr [CH_CNT];
   logic [REG_CNT*BYTE_W-1:0] dr_arr  [CH_CNT];

   qwe_decode u_dec (.instr(byte_data), .cmd(dec));

   assign take       = cs_active && byte_valid;
   assign instr_take = take && (state == ST_INSTR);
   assign data_take  = take && (state == ST_DATA);
   assign xfr_fire   = instr_take && (dec.op == OP_XFR);
   assign wcr_fire   = data_take && (cur.op == OP_WR_WCR);
   assign dr_req     = data_take && (cur.op == OP_WR_DR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_INSTR;
         cur      <= '{op: OP_NONE, rsel: '0, ch: '0};
         rd_byte  <= '0;
         rd_valid <= 1'b0;
         boot_q   <= 1'b1;
      end else begin
         boot_q   <= 1'b0;
         rd_valid <= 1'b0;
         if (!cs_active) begin
            state <= ST_INSTR;
         end else if (byte_valid) begin
            unique case (state)
               ST_INSTR: begin
                  cur <= dec;
                  unique case (dec.op)
                     OP_RD_WCR: begin
                        rd_byte  <= wcr_arr[dec.ch];
                        rd_valid <= 1'b1;
                        state    <= ST_DONE;
                     end
                     OP_RD_DR: begin
                        rd_byte  <= dr_arr[dec.ch][{dec.rsel, 3'b000} +: BYTE_W];
                        rd_valid <= 1'b1;
                        state    <= ST_DONE;
                     end
                     OP_WR_WCR, OP_WR_DR: state <= ST_DATA;
                     default:             state <= ST_DONE;
                  endcase
               end
               default: state <= ST_DONE;
            endcase
         end
      end
   end

   qwe_nv_timer #(.NV_DELAY(NV_DELAY)) u_nv (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (dr_req),
      .wp_n       (wp_n),
      .req_ch     (cur.ch),
      .req_rsel   (cur.rsel),
      .req_data   (byte_data),
      .wip        (wip),
      .commit     (commit),
      .commit_ch  (commit_ch),
      .commit_rsel(commit_rsel),
      .commit_data(commit_data)
   );

   generate
      for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
         qwe_channel #(.DR_SEED(DR_SEED), .CH_IDX(c)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .boot     (boot_q),
            .wcr_we   (wcr_fire && (cur.ch == CH_W'(c))),
            .wcr_wdata(byte_data),
            .xfr_en   (xfr_fire && (dec.ch == CH_W'(c))),
            .xfr_sel  (dec.rsel),
            .dr_we    (commit && (commit_ch == CH_W'(c))),
            .dr_sel   (commit_rsel),
            .dr_wdata (commit_data),
            .wcr      (wcr_arr[c]),
            .dr_flat  (dr_arr[c])
         );
         assign wiper_pos[c*BYTE_W +: BYTE_W] = wcr_arr[c];
      end
   endgenerate
endmodule

// File: rtl/qwe_engine_chk.sv
module qwe_engine_chk #(
   parameter int NV_DELAY = 20
)(
   input logic        clk,
   input logic        rst_n,
   input logic        cs_active,
   input logic        byte_valid,
   input logic        wp_n,
   input logic        rd_valid,
   input logic        wip,
   input logic [31:0] wiper_pos,
   input logic        boot
);
   int busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   busy_cnt <= 0;
      else if (wip) busy_cnt <= busy_cnt + 1;
      else          busy_cnt <= 0;
   end

   p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_rd_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(byte_valid && cs_active));

   p_wiper_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_pos) |-> ($past(byte_valid && cs_active) || $past(boot)));

   p_wip_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(byte_valid && cs_active && wp_n));

   p_wip_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wip |-> busy_cnt < NV_DELAY);

   p_wip_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && busy_cnt == NV_DELAY - 1) |=> !wip);

   p_wip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && busy_cnt < NV_DELAY - 1) |=> wip);

   p_wp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n |=> !$rose(wip));
endmodule

bind qwe_engine qwe_engine_chk #(.NV_DELAY(NV_DELAY)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_active (cs_active),
   .byte_valid(byte_valid),
   .wp_n      (wp_n),
   .rd_valid  (rd_valid),
   .wip       (wip),
   .wiper_pos (wiper_pos),
   .boot      (boot_q)
);

// File: tb/qwe_engine_tb.sv
module qwe_engine_tb;
   localparam int NV = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_active = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic        wp_n = 1'b1;
   logic [7:0]  rd_byte;
   logic        rd_valid;
   logic        wip;
   logic [31:0] wiper_pos;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   qwe_engine #(.NV_DELAY(NV), .DR_SEED(8'h40)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .byte_valid(byte_valid),
      .byte_data(byte_data), .wp_n(wp_n), .rd_byte(rd_byte), .rd_valid(rd_valid),
      .wip(wip), .wiper_pos(wiper_pos)
   );

   function automatic logic [7:0] seed_val(int c, int r);
      return 8'(8'h40 + c * 4 + r);
   endfunction

   function automatic logic [31:0] seed_wipers();
      return {seed_val(3, 0), seed_val(2, 0), seed_val(1, 0), seed_val(0, 0)};
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read bytes as the design returns them
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R10 unexpected read strobe: actual=%h expected=none", rd_byte);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (rd_byte !== e) begin
               bad++;
               $display("FAIL %s read: actual=%h expected=%h", t, rd_byte, e);
            end
         end
      end
   end

   task automatic frame_begin();
      @(negedge clk) cs_active = 1'b1;
   endtask

   task automatic frame_end();
      @(negedge clk) cs_active = 1'b0;
   endtask

   task automatic send(logic [7:0] b);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = b;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic do_write(logic [7:0] ins, logic [7:0] d);
      frame_begin();
      send(ins);
      send(d);
      frame_end();
   endtask

   task automatic do_read(logic [7:0] ins, logic [7:0] e, string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      frame_begin();
      send(ins);
      send(8'h00);
      frame_end();
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      cs_active = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && wip === 1'b1; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] snap;
      int n;
      do_reset();
      // R7: reset state, wipers copied from storage register 0
      chk(wiper_pos === seed_wipers(), "R7 boot wipers", wiper_pos, seed_wipers());
      chk(wip === 1'b0, "R7 wip after reset", 32'(wip), 0);
      chk(rd_valid === 1'b0, "R7 rd_valid after reset", 32'(rd_valid), 0);
      do_read({4'b1011, 2'd3, 2'd2}, seed_val(2, 3), "R4 R1 seed ch2 reg3");
      do_read({4'b1011, 2'd1, 2'd0}, seed_val(0, 1), "R4 R1 seed ch0 reg1");

      // R2: wiper read
      do_read({4'b1001, 2'd0, 2'd1}, seed_val(1, 0), "R2 wiper ch1");

      // R3: wiper writes at both ends of the range
      do_write({4'b1010, 2'd0, 2'd3}, 8'hFF);
      chk(wiper_pos[31:24] === 8'hFF, "R3 ch3 high end", wiper_pos[31:24], 8'hFF);
      do_write({4'b1010, 2'd0, 2'd0}, 8'h00);
      chk(wiper_pos[7:0] === 8'h00, "R3 ch0 low end", wiper_pos[7:0], 8'h00);
      do_read({4'b1001, 2'd0, 2'd3}, 8'hFF, "R2 R3 readback ch3");

      // R5: timed storage write
      frame_begin();
      send({4'b1100, 2'd2, 2'd1});
      send(8'h5A);
      n = 0;
      while (wip === 1'b1 && n < 1000) begin
         n++;
         @(negedge clk);
      end
      frame_end();
      chk(n == NV, "R5 busy length", 32'(n), 32'(NV));
      do_read({4'b1011, 2'd2, 2'd1}, 8'h5A, "R5 committed ch1 reg2");

      // R6: storage to wiper copy
      frame_begin();
      send({4'b1101, 2'd2, 2'd1});
      chk(wiper_pos[15:8] === 8'h5A, "R6 transfer ch1", wiper_pos[15:8], 8'h5A);
      frame_end();

      // R8: write protect
      wp_n = 1'b0;
      do_write({4'b1100, 2'd1, 2'd0}, 8'h77);
      chk(wip === 1'b0, "R8 wip stays low", 32'(wip), 0);
      wp_n = 1'b1;
      do_read({4'b1011, 2'd1, 2'd0}, seed_val(0, 1), "R8 protected reg unchanged");

      // R9: busy window ignores a second write, old value read while pending
      do_write({4'b1100, 2'd3, 2'd2}, 8'h11);
      chk(wip === 1'b1, "R9 busy started", 32'(wip), 1);
      do_write({4'b1100, 2'd0, 2'd2}, 8'h22);
      do_read({4'b1011, 2'd3, 2'd2}, seed_val(2, 3), "R9 old value while busy");
      chk(wip === 1'b1, "R9 still busy during read", 32'(wip), 1);
      wait_idle();
      do_read({4'b1011, 2'd3, 2'd2}, 8'h11, "R9 first write committed");
      do_read({4'b1011, 2'd0, 2'd2}, seed_val(2, 0), "R9 second write dropped");

      // R10: illegal instructions change nothing
      snap = wiper_pos;
      do_write({4'b1010, 2'd2, 2'd2}, 8'h33);
      do_write({4'b1001, 2'd1, 2'd1}, 8'h00);
      do_write(8'h0F, 8'h44);
      do_write(8'hE0, 8'h55);
      chk(wiper_pos === snap, "R10 wipers unchanged", wiper_pos, snap);
      chk(wip === 1'b0, "R10 no storage write", 32'(wip), 0);
      do_read({4'b1011, 2'd0, 2'd0}, seed_val(0, 0), "R10 storage unchanged");

      // R1: surplus bytes ignored, frame drop resynchronises
      frame_begin();
      send({4'b1010, 2'd0, 2'd0});
      send(8'h10);
      send({4'b1010, 2'd0, 2'd1});
      send(8'h99);
      frame_end();
      chk(wiper_pos[7:0] === 8'h10, "R1 first command done", wiper_pos[7:0], 8'h10);
      chk(wiper_pos[15:8] === 8'h5A, "R1 surplus bytes ignored", wiper_pos[15:8], 8'h5A);
      frame_begin();
      send({4'b1010, 2'd0, 2'd2});
      frame_end();
      do_read({4'b1001, 2'd0, 2'd0}, 8'h10, "R1 resync after abort");
      chk(wiper_pos[23:16] === seed_val(2, 0), "R1 aborted write", wiper_pos[23:16],
          seed_val(2, 0));

      // R7: a second reset reloads every wiper from storage register 0
      do_reset();
      chk(wiper_pos === seed_wipers(), "R7 reload after reset", wiper_pos, seed_wipers());

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 R4 all reads returned", exp_q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule